// File: doc/BRIEF.md
# Packed Integer Lane Arithmetic Unit

This block computes one 64-bit result from two 64-bit operands, treating the operands as vectors of independent lanes. An operation code picks the function: lane add or subtract in wrap, signed-clamp or unsigned-clamp form; 16-bit lane multiply keeping the low or high product half; lane compares that yield masks; or a whole-word logic function. A two-bit width select sets the lane width for add, subtract and compare.

The caller presents the operands, the operation and the width together with a one-cycle `go` pulse. One cycle later `done` pulses for one cycle and `res` carries the answer. `res` keeps that value until the next `go` is accepted. There are no flags: a carry or overflow never leaves its lane, and no overflow is reported.

Top module: `lane_alu`

## Requirements
- R1: Width select `wsel` encodes 0 = 8-bit lanes (eight), 1 = 16-bit lanes (four), 2 = 32-bit lanes (two). For add, subtract and compare, `wsel` = 3 yields a zero result.
- R2: ADD (op 0) and SUB (op 1) wrap modulo 2^w in each lane, with no effect on any other lane.
- R3: ADDS (op 2) and SUBS (op 3) treat lanes as two's-complement and clamp each result to [-2^(w-1), 2^(w-1)-1], e.g. -128..127 for bytes.
- R4: ADDUS (op 4) and SUBUS (op 5) treat lanes as unsigned and clamp each result to [0, 2^w-1], e.g. 0..255 for bytes.
- R5: MULLO (op 6) multiplies the four 16-bit lane pairs as signed values and returns the low 16 bits of each 32-bit product. `wsel` is ignored.
- R6: MULHI (op 7) returns the upper 16 bits of each signed product, and MULHIU (op 8) returns the upper 16 bits of each unsigned product. `wsel` is ignored.
- R7: CMPEQ (op 9) sets a lane to all ones when the two lanes are equal and to all zeros otherwise. CMPGT (op 10) does the same for a signed a > b.
- R8: AND (op 11), ANDN (op 12, computes ~a & b), OR (op 13) and XOR (op 14) act on all 64 bits and ignore `wsel`. Op 15 yields zero.
- R9: `done` is high exactly in the cycle after a cycle with `go` high, and low after reset.
- R10: `res` is zero after reset, loads only on a `go` cycle, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe; operands are sampled on this edge |
| op | input | 4 | Operation code |
| wsel | input | 2 | Lane width select |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| done | output | 1 | One-cycle pulse when the result is new |
| res | output | 64 | Registered result |

## Verification
The hardest cases to reach are the clamp boundaries: a lane must sit exactly at its limit or one step beyond it, while the neighbouring lanes do something different so that a carry leaking between lanes would be seen. The bench sweeps every pair of byte values drawn from a grid that includes 0, 1, 0x7F, 0x80, 0xFE and 0xFF. Each pair goes into one lane, and the other lanes receive their own distinct pairs. Each pair is run through every operation and width, including the reserved width. A pseudo-random sweep then covers the 16-bit multiply halves and the 32-bit lanes.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam int WORD_W = 64;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_ADDS   = 4'd2,
    OP_SUBS   = 4'd3,
    OP_ADDUS  = 4'd4,
    OP_SUBUS  = 4'd5,
    OP_MULLO  = 4'd6,
    OP_MULHI  = 4'd7,
    OP_MULHIU = 4'd8,
    OP_CMPEQ  = 4'd9,
    OP_CMPGT  = 4'd10,
    OP_AND    = 4'd11,
    OP_ANDN   = 4'd12,
    OP_OR     = 4'd13,
    OP_XOR    = 4'd14,
    OP_NONE   = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    ARITH_WRAP = 2'd0,
    ARITH_SSAT = 2'd1,
    ARITH_USAT = 2'd2
  } arith_e;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
  import lane_alu_pkg::*;
#(
  parameter int LW    = 8,
  parameter int WORDW = 64,
  localparam int NL   = WORDW / LW
) (
  input  logic [WORDW-1:0] a,
  input  logic [WORDW-1:0] b,
  input  logic             sub,
  input  arith_e           mode,
  output logic [WORDW-1:0] sum,
  output logic [NL-1:0]    clamp_hi,
  output logic [NL-1:0]    clamp_lo
);
  // lane result with saturation; ext is LW+2 bits, sign-extended or zero-extended
  function automatic logic [LW+1:0] ext_op(input logic [LW-1:0] v, input logic sgn);
    ext_op = sgn ? {{2{v[LW-1]}}, v} : {2'b00, v};
  endfunction

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      logic [LW-1:0] la, lb;
      logic [LW+1:0] xa, xb, full;
      logic          sgn;
      logic [LW-1:0] maxv, minv;
      assign la   = a[g*LW +: LW];
      assign lb   = b[g*LW +: LW];
      assign sgn  = (mode == ARITH_SSAT);
      assign xa   = ext_op(la, sgn);
      assign xb   = ext_op(lb, sgn);
      assign full = sub ? (xa - xb) : (xa + xb);
      assign maxv = sgn ? {1'b0, {(LW-1){1'b1}}} : {LW{1'b1}};
      assign minv = sgn ? {1'b1, {(LW-1){1'b0}}} : {LW{1'b0}};
      always_comb begin
        clamp_hi[g] = 1'b0;
        clamp_lo[g] = 1'b0;
        if (mode == ARITH_SSAT) begin
          clamp_hi[g] = !full[LW+1] && (full[LW] || full[LW-1]);
          clamp_lo[g] =  full[LW+1] && !(full[LW] && full[LW-1]);
        end else if (mode == ARITH_USAT) begin
          clamp_hi[g] = !sub && full[LW];
          clamp_lo[g] =  sub && full[LW+1];
        end
        if (clamp_hi[g])      sum[g*LW +: LW] = maxv;
        else if (clamp_lo[g]) sum[g*LW +: LW] = minv;
        else                  sum[g*LW +: LW] = full[LW-1:0];
      end
      // R3 / R4: a lane never clamps to both limits at once
      always_comb begin
        assert_one_clamp_R3: assert (!(clamp_hi[g] && clamp_lo[g]));
      end
    end
  endgenerate
endmodule

// File: rtl/lane_cmp.sv
module lane_cmp #(
  parameter int LW    = 8,
  parameter int WORDW = 64,
  localparam int NL   = WORDW / LW
) (
  input  logic [WORDW-1:0] a,
  input  logic [WORDW-1:0] b,
  input  logic             gt,
  output logic [WORDW-1:0] mask
);
  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      logic hit;
      assign hit = gt ? ($signed(a[g*LW +: LW]) > $signed(b[g*LW +: LW]))
                      : (a[g*LW +: LW] == b[g*LW +: LW]);
      assign mask[g*LW +: LW] = {LW{hit}};
    end
  endgenerate
endmodule

// File: rtl/lane_mul16.sv
module lane_mul16 #(
  parameter int WORDW = 64,
  localparam int MW   = 16,
  localparam int NL   = WORDW / MW
) (
  input  logic [WORDW-1:0] a,
  input  logic [WORDW-1:0] b,
  input  logic             hi,
  input  logic             uns,
  output logic [WORDW-1:0] prod
);
  function automatic logic [2*MW-1:0] mul_lane(input logic [MW-1:0] x,
                                               input logic [MW-1:0] y,
                                               input logic u);
    logic [2*MW-1:0] xe, ye;
    xe = u ? {{MW{1'b0}}, x} : {{MW{x[MW-1]}}, x};
    ye = u ? {{MW{1'b0}}, y} : {{MW{y[MW-1]}}, y};
    mul_lane = xe * ye;
  endfunction

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      logic [2*MW-1:0] p;
      assign p = mul_lane(a[g*MW +: MW], b[g*MW +: MW], uns);
      assign prod[g*MW +: MW] = hi ? p[2*MW-1:MW] : p[MW-1:0];
    end
  endgenerate
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int WORDW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [3:0]       op,
  input  logic [1:0]       wsel,
  input  logic [WORDW-1:0] a,
  input  logic [WORDW-1:0] b,
  output logic             done,
  output logic [WORDW-1:0] res
);
  localparam int NW = 3;  // number of lane widths
  op_e    opc;
  logic   is_sub;
  arith_e amode;
  logic [WORDW-1:0] as_res [NW];
  logic [WORDW-1:0] cm_res [NW];
  logic [WORDW-1:0] mul_res, nxt;

  assign opc    = op_e'(op);
  assign is_sub = (opc == OP_SUB) || (opc == OP_SUBS) || (opc == OP_SUBUS);
  always_comb begin
    case (opc)
      OP_ADDS, OP_SUBS:   amode = ARITH_SSAT;
      OP_ADDUS, OP_SUBUS: amode = ARITH_USAT;
      default:            amode = ARITH_WRAP;
    endcase
  end

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_width
      localparam int LW = 8 << w;
      logic [WORDW/LW-1:0] chi, clo;
      lane_addsub #(.LW(LW), .WORDW(WORDW)) u_as (
        .a(a), .b(b), .sub(is_sub), .mode(amode),
        .sum(as_res[w]), .clamp_hi(chi), .clamp_lo(clo));
      lane_cmp #(.LW(LW), .WORDW(WORDW)) u_cm (
        .a(a), .b(b), .gt(opc == OP_CMPGT), .mask(cm_res[w]));
    end
  endgenerate

  lane_mul16 #(.WORDW(WORDW)) u_mul (
    .a(a), .b(b), .hi(opc != OP_MULLO), .uns(opc == OP_MULHIU), .prod(mul_res));

  always_comb begin
    nxt = '0;
    case (opc)
      OP_ADD, OP_SUB, OP_ADDS, OP_SUBS, OP_ADDUS, OP_SUBUS:
        if (wsel != 2'd3) nxt = as_res[wsel];
      OP_CMPEQ, OP_CMPGT:
        if (wsel != 2'd3) nxt = cm_res[wsel];
      OP_MULLO, OP_MULHI, OP_MULHIU: nxt = mul_res;
      OP_AND:  nxt = a & b;
      OP_ANDN: nxt = ~a & b;
      OP_OR:   nxt = a | b;
      OP_XOR:  nxt = a ^ b;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      res  <= '0;
    end else begin
      done <= go;
      if (go) res <= nxt;
    end
  end

  assert_done_follows_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !done);
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(res));
  assert_reserved_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wsel == 2'd3 && op <= 4'd5) |=> (res == '0));
  assert_cmp_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wsel == 2'd0 && (op == 4'd9 || op == 4'd10)) |=>
      ((res[7:0] == 8'h00) || (res[7:0] == 8'hFF)));
endmodule

// File: tb/lane_alu_tb.sv
module lane_alu_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, go = 0;
  logic [3:0] op = 0;
  logic [1:0] wsel = 0;
  logic [63:0] a = 0, b = 0;
  logic done;
  logic [63:0] res;
  int nvec = 0, nfail = 0;
  bit finished = 0;

  lane_alu u_dut (.clk(clk), .rst_n(rst_n), .go(go), .op(op), .wsel(wsel),
                  .a(a), .b(b), .done(done), .res(res));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint lane_s(logic [63:0] v, int lo, int w);
    longint x = 0;
    for (int i = 0; i < w; i++) x[i] = v[lo+i];
    if (v[lo+w-1]) x = x - (longint'(1) << w);
    return x;
  endfunction
  function automatic longint lane_u(logic [63:0] v, int lo, int w);
    longint x = 0;
    for (int i = 0; i < w; i++) x[i] = v[lo+i];
    return x;
  endfunction

  function automatic logic [63:0] model(int o, int ws, logic [63:0] x, logic [63:0] y);
    logic [63:0] r = 0;
    int w;
    longint s, lo, hi, m;
    if (o <= 10 && o != 6 && o != 7 && o != 8) begin
      if (ws == 3) return 0;
      w = 8 * (1 << ws);
      for (int l = 0; l < 64 / w; l++) begin
        if (o == 2 || o == 3 || o == 10) begin
          s = (o == 3) ? lane_s(x, l*w, w) - lane_s(y, l*w, w)
                       : lane_s(x, l*w, w) + lane_s(y, l*w, w);
        end else begin
          s = (o == 1 || o == 5) ? lane_u(x, l*w, w) - lane_u(y, l*w, w)
                                 : lane_u(x, l*w, w) + lane_u(y, l*w, w);
        end
        if (o == 2 || o == 3) begin
          hi = (longint'(1) << (w-1)) - 1; lo = -(longint'(1) << (w-1));
          if (s > hi) s = hi; if (s < lo) s = lo;
        end
        if (o == 4 || o == 5) begin
          hi = (longint'(1) << w) - 1;
          if (s > hi) s = hi; if (s < 0) s = 0;
        end
        if (o == 9)  s = (lane_u(x, l*w, w) == lane_u(y, l*w, w)) ? -1 : 0;
        if (o == 10) s = (lane_s(x, l*w, w) > lane_s(y, l*w, w)) ? -1 : 0;
        for (int i = 0; i < w; i++) r[l*w+i] = s[i];
      end
      return r;
    end
    if (o >= 6 && o <= 8) begin
      for (int l = 0; l < 4; l++) begin
        m = (o == 8) ? lane_u(x, l*16, 16) * lane_u(y, l*16, 16)
                     : lane_s(x, l*16, 16) * lane_s(y, l*16, 16);
        for (int i = 0; i < 16; i++) r[l*16+i] = (o == 6) ? m[i] : m[16+i];
      end
      return r;
    end
    case (o)
      11: return x & y;
      12: return ~x & y;
      13: return x | y;
      14: return x ^ y;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int o, int ws);
    if (ws == 3 && (o <= 5 || o == 9 || o == 10)) return "R1";
    if (o <= 1) return "R2";
    if (o <= 3) return "R3";
    if (o <= 5) return "R4";
    if (o == 6) return "R5";
    if (o <= 8) return "R6";
    if (o <= 10) return "R7";
    return "R8";
  endfunction

  task automatic apply(int o, int ws, logic [63:0] x, logic [63:0] y);
    logic [63:0] exp;
    @(negedge clk);
    op = 4'(o); wsel = 2'(ws); a = x; b = y; go = 1;
    @(negedge clk);
    go = 0;
    exp = model(o, ws, x, y);
    nvec++;
    if (!done) begin
      nfail++;
      $display("FAIL R9 done act=%0b exp=1", done);
    end
    if (res !== exp) begin
      nfail++;
      $display("FAIL %s op=%0d wsel=%0d a=%h b=%h act=%h exp=%h",
               req_of(o, ws), o, ws, x, y, res, exp);
    end
  endtask

  logic [7:0] grid [10] = '{8'h00, 8'h01, 8'h02, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hC0, 8'hFE, 8'hFF};

  initial begin
    logic [63:0] x, y, held;
    logic [63:0] lfsr = 64'hACE1_2468_1357_BDF0;
    repeat (3) @(negedge clk);
    // reset state
    nvec++;
    if (done !== 1'b0 || res !== 64'd0) begin
      nfail++;
      $display("FAIL R9/R10 reset act=%b/%h exp=0/0", done, res);
    end
    rst_n = 1;
    // grid sweep: lane 0 takes the grid pair; the other lanes take distinct neighbours
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++) begin
        x = '0; y = '0;
        for (int l = 0; l < 8; l++) begin
          x[l*8 +: 8] = grid[(i + l) % 10];
          y[l*8 +: 8] = grid[(j + 3*l) % 10];
        end
        for (int o = 0; o < 16; o++)
          for (int ws = 0; ws < 4; ws++) apply(o, ws, x, y);
      end
    // pseudo-random sweep covering 16/32-bit lanes and multiply halves
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      x = lfsr * 64'h9E37_79B9_7F4A_7C15;
      y = {x[31:0], x[63:32]} ^ lfsr;
      for (int o = 0; o < 16; o++) apply(o, k % 3, x, y);
    end
    // R10 hold: with go low and inputs changing, res and done must not move
    held = res;
    @(negedge clk);
    a = ~a; b = ~b; op = 4'd14;
    repeat (3) @(negedge clk);
    nvec++;
    if (res !== held || done !== 1'b0) begin
      nfail++;
      $display("FAIL R10 hold act=%h/%b exp=%h/0", res, done, held);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule